// File: doc/BRIEF.md
# Dual-Mode Serial Result Port for a 16-Bit Sampling Converter

This block is the digital back end of a successive-approximation converter. It watches the chip-select and read/convert lines to start conversions and drops busy while the converter works. When the converter core raises its done strobe, the block stores the new raw result. It then shifts stored results out on a single data line, most significant bit first. Results can leave in straight binary or in two's complement, and the two codings differ only in the top bit.

Two clocking modes exist. In internal mode, every conversion start also sends the result of the previous conversion, paced by sixteen data-clock pulses that the block generates itself. Between transfers the data line holds the tag level captured at that start. In external mode the host supplies the data clock, and a separate read event produces a sync pulse followed by the stored word. A read after busy has risen returns the newest result; a read during a conversion returns the one before it. After the word, the data line carries the tag input delayed by sixteen data-clock edges, so several converters can be chained on one line. All inputs are synchronous to `clk`. The external data clock is sampled by `clk`, and the block acts on its rising edges.

Top module: `adc_serial_port`

## Requirements
- R1: With `fmt_sb_i` high a word is sent unchanged (straight binary); with it low only bit 15 is inverted, so raw FFFF, 8000 and 0000 go out as 7FFF, 0000 and 8000. The coding is taken at the moment the word is loaded for sending.
- R2: In internal mode (`ext_mode_i` low), a conversion start loads the previously stored result and sends it MSB first over 16 pulses on `dclk_out_o`. Each bit spans one low phase and one high phase of DCLK_HALF clock cycles each, starting low in the cycle after the start. After the sixteenth pulse `dclk_out_o` stays low.
- R3: In internal mode, outside a transfer `sdata_o` equals the `tag_i` level sampled in the start cycle. Changes of `tag_i` after the start have no effect on it.
- R4: A conversion start is a falling edge of (`cs_n_i` OR `rd_cnv_i`) while `busy_o` is high and `pwr_dn_i` is low. `busy_o` falls in the next cycle. While `busy_o` is low, a `conv_done_i` pulse stores `result_i`, and `busy_o` rises in the next cycle.
- R5: While `pwr_dn_i` is high, start edges are ignored: `busy_o` stays high, no data-clock pulse is produced and the stored result is kept.
- R6: In external mode, a read starts on a rising `rd_cnv_i` with `cs_n_i` low, or on a falling `cs_n_i` with `rd_cnv_i` high. On the first rising `dclk_in_i` edge after that, `sync_o` goes high for exactly one data-clock period, and bit 15 appears on `sdata_o`.
- R7: In external mode the word is the stored result at that first edge. A read after `busy_o` rose gives conversion n; a read while `busy_o` is low gives conversion n-1. Each later rising edge presents the next lower bit.
- R8: In external mode, after the 16 bits `sdata_o` shows the `tag_i` value sampled 16 rising edges earlier. When `cs_n_i` goes high or `rd_cnv_i` goes low, the read ends and `sdata_o` and `sync_o` return to 0 in the next cycle.
- R9: In external mode `dclk_drive_o` is 0 and `dclk_out_o` stays low; in internal mode `dclk_drive_o` is 1.
- R10: A `conv_done_i` pulse while `busy_o` is high does not change the stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| rd_cnv_i | input | 1 | Read (high) / convert (low) control |
| ext_mode_i | input | 1 | 1 = external data clock, 0 = internal |
| fmt_sb_i | input | 1 | 1 = straight binary, 0 = two's complement |
| tag_i | input | 1 | Tag / daisy-chain serial input |
| pwr_dn_i | input | 1 | Power down: blocks conversion starts |
| conv_done_i | input | 1 | One-cycle strobe from the converter core |
| result_i | input | W | Raw straight-binary conversion result |
| dclk_in_i | input | 1 | Host data clock used in external mode |
| busy_o | output | 1 | Low while a conversion is in progress |
| sync_o | output | 1 | One-data-clock frame marker (external mode) |
| sdata_o | output | 1 | Serial data output |
| dclk_out_o | output | 1 | Generated data clock (internal mode) |
| dclk_drive_o | output | 1 | 1 when the block drives the data clock |

## Verification
A corrupted stored result shows up as a wrong bit on `sdata_o` during the first transfer that follows, within one bit time of the bad bit position. A wrong phase or pulse counter in the generator makes `dclk_out_o` differ from the model within DCLK_HALF cycles. A lost read phase shows as a missing or doubled `sync_o` pulse at the next host clock edge. An off-by-one in the tag path shifts the tag stream by one bit, visible on the seventeenth edge after sync. A busy flag stuck in the wrong state is exposed on the cycle after the next start or done strobe.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ARMED = 2'd1,
        RD_SHIFT = 2'd2
    } rd_phase_t;
endpackage

// File: rtl/adc_sp_fmt.sv
module adc_sp_fmt #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw_i,
    input  logic         straight_i,
    output logic [W-1:0] coded_o
);
    always_comb begin
        coded_o        = raw_i;
        coded_o[W-1]   = raw_i[W-1] ^ ~straight_i;
    end
endmodule

// File: rtl/adc_sp_pulsegen.sv
module adc_sp_pulsegen #(
    parameter int W    = 16,
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic lvl_o,
    output logic fall_o,
    output logic last_o,
    output logic act_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int PW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          act;
        logic          lvl;
        logic [CW-1:0] cnt;
        logic [PW-1:0] pcnt;
    } pg_t;

    pg_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        fall_o = 1'b0;
        last_o = 1'b0;
        if (go_i) begin
            s_d.act  = 1'b1;
            s_d.lvl  = 1'b0;
            s_d.cnt  = '0;
            s_d.pcnt = '0;
        end else if (s_q.act) begin
            if (s_q.cnt == CW'(HALF - 1)) begin
                s_d.cnt = '0;
                s_d.lvl = ~s_q.lvl;
                if (s_q.lvl) begin
                    fall_o   = 1'b1;
                    s_d.pcnt = s_q.pcnt + 1'b1;
                    if (s_q.pcnt == PW'(W - 1)) begin
                        last_o  = 1'b1;
                        s_d.act = 1'b0;
                    end
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl_o = s_q.lvl;
    assign act_o = s_q.act;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
    parameter int W          = 16,
    parameter int DCLK_HALF  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n_i,
    input  logic         rd_cnv_i,
    input  logic         ext_mode_i,
    input  logic         fmt_sb_i,
    input  logic         tag_i,
    input  logic         pwr_dn_i,
    input  logic         conv_done_i,
    input  logic [W-1:0] result_i,
    input  logic         dclk_in_i,
    output logic         busy_o,
    output logic         sync_o,
    output logic         sdata_o,
    output logic         dclk_out_o,
    output logic         dclk_drive_o
);
    import adc_sp_pkg::*;

    typedef struct packed {
        logic        busy;
        logic [W-1:0] hold;
        logic [W-1:0] sh;
        logic        sdata;
        logic        sync;
        rd_phase_t   rph;
        logic        tagcap;
        logic        prev_sel;
        logic        prev_cs;
        logic        prev_rd;
        logic        prev_dclk;
    } st_t;

    st_t s_d, s_q;

    logic         sel, start, trig, rd_ok, rise, go;
    logic [W-1:0] word;
    logic         pg_lvl, pg_fall, pg_last, pg_act;

    adc_sp_fmt #(.W(W)) u_fmt (
        .raw_i      (s_q.hold),
        .straight_i (fmt_sb_i),
        .coded_o    (word)
    );

    adc_sp_pulsegen #(.W(W), .HALF(DCLK_HALF)) u_pg (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .lvl_o  (pg_lvl),
        .fall_o (pg_fall),
        .last_o (pg_last),
        .act_o  (pg_act)
    );

    always_comb begin
        sel   = cs_n_i | rd_cnv_i;
        start = s_q.prev_sel & ~sel & s_q.busy & ~pwr_dn_i;
        trig  = ext_mode_i & ((~s_q.prev_rd & rd_cnv_i & ~cs_n_i) |
                              (s_q.prev_cs & ~cs_n_i & rd_cnv_i));
        rd_ok = ~cs_n_i & rd_cnv_i;
        rise  = dclk_in_i & ~s_q.prev_dclk;
        go    = start & ~ext_mode_i;

        s_d           = s_q;
        s_d.prev_sel  = sel;
        s_d.prev_cs   = cs_n_i;
        s_d.prev_rd   = rd_cnv_i;
        s_d.prev_dclk = dclk_in_i;

        if (start) begin
            s_d.busy = 1'b0;
        end else if (conv_done_i && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.hold = result_i;
        end

        if (!ext_mode_i) begin
            s_d.sync = 1'b0;
            s_d.rph  = RD_IDLE;
            if (go) begin
                s_d.sdata  = word[W-1];
                s_d.sh     = {word[W-2:0], 1'b0};
                s_d.tagcap = tag_i;
            end else if (pg_fall) begin
                if (pg_last) begin
                    s_d.sdata = s_q.tagcap;
                end else begin
                    s_d.sdata = s_q.sh[W-1];
                    s_d.sh    = {s_q.sh[W-2:0], 1'b0};
                end
            end else if (!pg_act) begin
                s_d.sdata = s_q.tagcap;
            end
        end else if (!rd_ok) begin
            s_d.rph   = RD_IDLE;
            s_d.sync  = 1'b0;
            s_d.sdata = 1'b0;
        end else if (trig) begin
            s_d.rph  = RD_ARMED;
            s_d.sync = 1'b0;
        end else if (rise) begin
            case (s_q.rph)
                RD_ARMED: begin
                    s_d.sdata = word[W-1];
                    s_d.sh    = {word[W-2:0], tag_i};
                    s_d.sync  = 1'b1;
                    s_d.rph   = RD_SHIFT;
                end
                RD_SHIFT: begin
                    s_d.sdata = s_q.sh[W-1];
                    s_d.sh    = {s_q.sh[W-2:0], tag_i};
                    s_d.sync  = 1'b0;
                end
                default: s_d.rph = RD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.busy <= 1'b1;
            s_q.rph  <= RD_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = s_q.busy;
    assign sync_o       = s_q.sync;
    assign sdata_o      = s_q.sdata;
    assign dclk_out_o   = pg_lvl & ~ext_mode_i;
    assign dclk_drive_o = ~ext_mode_i;
endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk #(
    parameter int HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic rd_cnv_i,
    input logic pwr_dn_i,
    input logic conv_done_i,
    input logic dclk_in_i,
    input logic busy_o,
    input logic sync_o,
    input logic dclk_out_o
);
    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(conv_done_i));

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(!pwr_dn_i));

    // R6
    sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> ($past(dclk_in_i) && !$past(dclk_in_i, 2)));

    // R8
    sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_i || !rd_cnv_i) |-> !sync_o);

    // R2
    dclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dclk_out_o) && HALF > 1) |=> dclk_out_o);
endmodule

bind adc_serial_port adc_sp_chk #(.HALF(DCLK_HALF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .rd_cnv_i    (rd_cnv_i),
    .pwr_dn_i    (pwr_dn_i),
    .conv_done_i (conv_done_i),
    .dclk_in_i   (dclk_in_i),
    .busy_o      (busy_o),
    .sync_o      (sync_o),
    .dclk_out_o  (dclk_out_o)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 16;
    localparam int HALF = 2;
    localparam int XFER = 2 * HALF * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_cnv = 1'b1, ext_mode = 1'b0, fmt_sb = 1'b1;
    logic tag_in = 1'b0, pwr_dn = 1'b0, done = 1'b0, dclk_in = 1'b0;
    logic [W-1:0] result = '0;
    logic busy, sync, sdata, dclk_out, dclk_drive;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R4";
    bit ext_run = 0;
    bit tag_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_port #(.W(W), .DCLK_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .rd_cnv_i(rd_cnv),
        .ext_mode_i(ext_mode), .fmt_sb_i(fmt_sb), .tag_i(tag_in),
        .pwr_dn_i(pwr_dn), .conv_done_i(done), .result_i(result),
        .dclk_in_i(dclk_in), .busy_o(busy), .sync_o(sync), .sdata_o(sdata),
        .dclk_out_o(dclk_out), .dclk_drive_o(dclk_drive)
    );

    function automatic logic [W-1:0] fmtw(input logic [W-1:0] raw, input logic sb);
        return sb ? raw : (raw ^ (1 << (W - 1)));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // reference model
    bit m_busy, m_psel, m_pcs, m_prd, m_pdclk, m_sdata, m_sync, m_tagcap;
    int m_k, m_ph;
    logic [W-1:0] m_hold, m_word;
    bit q[$];
    bit ev, ev_tag;

    always @(posedge clk) begin
        bit sel, start, trig, rok, rise;
        logic [W-1:0] wnow;
        ev = 0;
        ev_tag = tag_in;
        if (!rst_n) begin
            m_busy = 1; m_psel = 0; m_pcs = 0; m_prd = 0; m_pdclk = 0;
            m_sdata = 0; m_sync = 0; m_tagcap = 0; m_k = -1; m_ph = 0;
            m_hold = '0; m_word = '0; q.delete();
        end else begin
            sel   = cs_n | rd_cnv;
            start = m_psel && !sel && m_busy && !pwr_dn;
            trig  = ext_mode && ((!m_prd && rd_cnv && !cs_n) || (m_pcs && !cs_n && rd_cnv));
            rok   = !cs_n && rd_cnv;
            rise  = dclk_in && !m_pdclk;
            wnow  = fmtw(m_hold, fmt_sb);
            if (start) m_busy = 0;
            else if (done && !m_busy) begin m_busy = 1; m_hold = result; end
            if (!ext_mode) begin
                m_sync = 0; m_ph = 0;
                if (start) begin m_word = wnow; m_tagcap = tag_in; m_k = 0; end
                else if (m_k >= 0) begin m_k++; if (m_k == XFER) m_k = -1; end
                m_sdata = (m_k >= 0) ? m_word[W-1-m_k/(2*HALF)] : m_tagcap;
            end else if (!rok) begin
                m_ph = 0; m_sync = 0; m_sdata = 0; q.delete();
            end else if (trig) begin
                m_ph = 1; m_sync = 0;
            end else if (rise && m_ph == 1) begin
                q.delete();
                for (int i = W - 2; i >= 0; i--) q.push_back(wnow[i]);
                q.push_back(tag_in);
                m_sdata = wnow[W-1]; m_sync = 1; m_ph = 2; ev = 1;
            end else if (rise && m_ph == 2) begin
                m_sdata = q.pop_front();
                q.push_back(tag_in);
                m_sync = 0; ev = 1;
            end
            m_psel = sel; m_pcs = cs_n; m_prd = rd_cnv; m_pdclk = dclk_in;
        end
    end

    bit cap[$];
    bit tagq[$];
    int sync_cnt;

    always @(negedge clk) begin
        bit exp_dclk;
        if (rst_n) begin
            exp_dclk = (!ext_mode && m_k >= 0) ? ((m_k / HALF) % 2 == 1) : 1'b0;
            check(busy == m_busy, "R4 busy", busy, m_busy);
            check(sync == m_sync, "R6 sync", sync, m_sync);
            check(sdata == m_sdata, {cur_req, " sdata"}, sdata, m_sdata);
            check(dclk_out == exp_dclk, ext_mode ? "R9 dclk_out" : "R2 dclk_out", dclk_out, exp_dclk);
            check(dclk_drive == !ext_mode, "R9 dclk_drive", dclk_drive, !ext_mode);
            if (ev) begin cap.push_back(sdata); tagq.push_back(ev_tag); end
            if (sync) sync_cnt++;
        end
    end

    // host data clock and tag stream
    initial begin
        int cnt = 0;
        logic [7:0] lfsr = 8'h5B;
        forever begin
            @(negedge clk);
            if (ext_run) begin
                cnt++;
                if (cnt == 3) begin cnt = 0; dclk_in = ~dclk_in; end
            end
            if (tag_run) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                tag_in = lfsr[0];
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic int_conv(input logic [W-1:0] raw, input logic sb, input logic tg,
                            input logic [W-1:0] exp, input string req);
        logic [W-1:0] w = '0;
        bit pd = 0;
        fmt_sb = sb; tag_in = tg;
        @(negedge clk) rd_cnv = 1'b0;
        @(negedge clk) rd_cnv = 1'b1; tag_in = ~tg;
        for (int i = 0; i < XFER + 8; i++) begin
            @(negedge clk);
            if (dclk_out && !pd) w = {w[W-2:0], sdata};
            pd = dclk_out;
            if (i == 10) begin done = 1'b1; result = raw; end
            if (i == 11) done = 1'b0;
        end
        check(w == exp, req, w, exp);
        check(sdata == tg, "R3 tag hold", sdata, tg);
    endtask

    task automatic collect(input int n);
        cap.delete(); tagq.delete(); sync_cnt = 0;
        for (int i = 0; i < 20 * n && cap.size() < n; i++) @(negedge clk);
    endtask

    function automatic logic [W-1:0] cap_word();
        logic [W-1:0] w = '0;
        for (int i = 0; i < W; i++) w = {w[W-2:0], cap[i]};
        return w;
    endfunction

    initial begin
        int rises;
        bit pd;
        repeat (3) @(negedge clk);
        check(busy == 1'b1 && sync == 1'b0 && sdata == 1'b0 && dclk_out == 1'b0,
              "R4 reset state", {busy, sync, sdata, dclk_out}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;

        cur_req = "R2";
        int_conv(16'hFFFF, 1'b1, 1'b1, 16'h0000, "R2 prev word after reset");
        cur_req = "R1";
        int_conv(16'h8000, 1'b1, 1'b0, 16'hFFFF, "R1 straight full scale");
        int_conv(16'h0000, 1'b0, 1'b1, 16'h0000, "R1 tc midscale");
        int_conv(16'hFFFF, 1'b0, 1'b0, 16'h8000, "R1 tc low");
        int_conv(16'h1234, 1'b0, 1'b1, 16'h7FFF, "R1 tc high");
        cur_req = "R2";
        int_conv(16'h8000, 1'b1, 1'b0, 16'h1234, "R2 previous result");

        cur_req = "R5";
        pwr_dn = 1'b1;
        @(negedge clk) rd_cnv = 1'b0;
        @(negedge clk) rd_cnv = 1'b1;
        rises = 0; pd = 0;
        for (int i = 0; i < XFER; i++) begin
            @(negedge clk);
            if (dclk_out && !pd) rises++;
            pd = dclk_out;
        end
        check(rises == 0, "R5 no pulses", rises, 0);
        check(busy == 1'b1, "R5 busy held", busy, 1);
        pwr_dn = 1'b0;

        cur_req = "R10";
        @(negedge clk) begin done = 1'b1; result = 16'hAAAA; end
        @(negedge clk) done = 1'b0;
        int_conv(16'h0000, 1'b1, 1'b1, 16'h8000, "R10 done ignored while idle");

        cur_req = "R7";
        @(negedge clk) begin cs_n = 1'b1; rd_cnv = 1'b1; fmt_sb = 1'b1; ext_mode = 1'b1; ext_run = 1; end
        repeat (10) @(negedge clk);
        check(dclk_drive == 1'b0 && dclk_out == 1'b0, "R9 external mode", {dclk_drive, dclk_out}, 0);

        // read after conversion
        @(negedge clk) rd_cnv = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1; result = 16'h5A5A;
        @(negedge clk) done = 1'b0;
        repeat (3) @(negedge clk);
        rd_cnv = 1'b1;
        collect(W + 4);
        check(cap_word() == 16'h5A5A, "R7 read after done", cap_word(), 16'h5A5A);
        check(sync_cnt == 6, "R6 sync width", sync_cnt, 6);
        cur_req = "R8";
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sdata == 1'b0 && sync == 1'b0, "R8 read end", {sdata, sync}, 0);

        // read during conversion
        cur_req = "R7";
        rd_cnv = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) rd_cnv = 1'b1;
        collect(W);
        check(cap_word() == 16'h5A5A, "R7 read during conversion", cap_word(), 16'h5A5A);
        check(busy == 1'b0, "R4 busy low during conversion", busy, 0);
        cs_n = 1'b1;
        @(negedge clk) begin done = 1'b1; result = 16'h0F0F; end
        @(negedge clk) done = 1'b0;

        // chip-select triggered read with tag stream
        cur_req = "R8";
        fmt_sb = 1'b0; tag_run = 1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        collect(W + 10);
        check(cap_word() == 16'h8F0F, "R6 cs-fall read word", cap_word(), 16'h8F0F);
        for (int i = 0; i < 10; i++)
            check(cap[W + i] == tagq[i], "R8 tag delay", cap[W + i], tagq[i]);
        cs_n = 1'b1; tag_run = 0;
        repeat (4) @(negedge clk);
        report();
    end
endmodule